// File: doc/BRIEF.md
# DRAM temperature derating selector

This block watches the refresh-rate status that a low-power DRAM reports in its temperature mode register. It picks the timing and refresh control words that the memory controller uses. A free-running count of refresh intervals starts a mode-register read at a fixed period. The read covers chip select 0 and, when a second rank is fitted, chip select 1. The higher of the two codes is filtered into a temperature level.

At some levels the block applies derated words in place of the nominal ones:
- Level 5 derates the refresh word only.
- Levels 6 and 7 derate both timing words and the refresh word.

A rise in temperature takes effect at once. A fall only takes effect when the deferred handler confirms it. Every change in the accepted reading raises a one-cycle alert. A part without extended-temperature rating turns any derating reading into a shutdown level. The active words are only reloaded in cycles where the command path reports it is between DRAM commands.

Top module: `temp_derate_sel`

## Requirements
- R1: A read sequence starts after every `poll_cnt_i` pulses of `refresh_tick_i`; `poll_cnt_i` = 0 stops polling.
- R2: When `cs1_used_i` is high, the block reads chip select 0 (`mr_cs_o`=0) and then chip select 1 (`mr_cs_o`=1), and uses the larger of the two 3-bit codes.
- R3: A code below 3 is taken as level 3 (nominal); the level after reset is 3.
- R4: Code 4 is reserved. It is discarded: no alert, and the level is unchanged.
- R5: A reading above the current level is applied in the cycle after the read completes. A lower reading is held pending, and is applied one cycle after a `fall_apply_i` pulse.
- R6: At level 5 only `ref_o` takes the derated word. At levels 6 and 7 `tim1_o`, `tim3_o` and `ref_o` all take derated words. At other levels all three are nominal.
- R7: `tim1_o`, `tim3_o` and `ref_o` only change on an edge where `cmd_idle_i` is high.
- R8: With `ext_temp_i` low, a reading of 5 or more becomes level 7. `shutdown_o` is high while the level is 7.
- R9: A poll that comes while a read is outstanding is dropped. `mr_req_o` stays high until `mr_ack_i`.
- R10: `alert_o` pulses for one cycle, together with any level rise, when a valid filtered reading differs from the previous accepted reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_tick_i | input | 1 | One pulse per refresh interval |
| poll_cnt_i | input | CNT_W | Poll period in refresh intervals, 0 = off |
| cs1_used_i | input | 1 | Second chip select fitted |
| ext_temp_i | input | 1 | Part rated for extended temperature |
| mr_req_o | output | 1 | Mode-register read request |
| mr_cs_o | output | 1 | Chip select of the current read |
| mr_ack_i | input | 1 | Read completion strobe |
| mr_data_i | input | 3 | Refresh-rate field of the read data |
| fall_apply_i | input | 1 | Deferred handler commits a pending fall |
| cmd_idle_i | input | 1 | Command path between DRAM commands |
| nom_tim1_i | input | TW | Nominal timing word 1 |
| nom_tim3_i | input | TW | Nominal timing word 3 |
| nom_ref_i | input | TW | Nominal refresh word |
| der_tim1_i | input | TW | Derated timing word 1 |
| der_tim3_i | input | TW | Derated timing word 3 |
| der_ref_i | input | TW | Derated refresh word |
| tim1_o | output | TW | Active timing word 1 |
| tim3_o | output | TW | Active timing word 3 |
| ref_o | output | TW | Active refresh word |
| level_o | output | 3 | Applied temperature level |
| alert_o | output | 1 | Level-change alert pulse |
| shutdown_o | output | 1 | Over-temperature shutdown |

## Verification
Some properties are checked on every cycle:
- The applied level never leaves the range 3, 5, 6, 7.
- The level never drops without a `fall_apply_i` pulse in the cycle before.
- The active words hold whenever the command path is busy.
- The read request is held until acknowledged, and a poll only fires after a tick with a non-zero period.

Other behaviour can only be shown by the bench's scenarios:
- The maximum across two chip selects.
- Discarding of the reserved code.
- Which words each level derates.
- The shutdown conversion for parts without extended rating.
- Dropping of polls during a slow read.
- The exact poll period.

// File: rtl/temp_derate_pkg.sv
package temp_derate_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_NOM  = 3'd3;
  localparam lvl_t LVL_RSVD = 3'd4;
  localparam lvl_t LVL_DREF = 3'd5;
  localparam lvl_t LVL_DALL = 3'd6;
  localparam lvl_t LVL_SHUT = 3'd7;

  typedef enum logic [1:0] {RD_IDLE, RD_CS0, RD_CS1} rd_state_e;

  function automatic logic lvl_ok(lvl_t raw);
    return raw != LVL_RSVD;
  endfunction

  function automatic lvl_t lvl_map(lvl_t raw, logic ext);
    lvl_t l;
    l = (raw < LVL_NOM) ? LVL_NOM : raw;
    if (!ext && l >= LVL_DREF) l = LVL_SHUT;
    return l;
  endfunction
endpackage

// File: rtl/tds_poll_timer.sv
module tds_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refresh_tick_i,
  input  logic [CNT_W-1:0] poll_cnt_i,
  output logic             poll_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  assign last_c = poll_cnt_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      poll_o <= 1'b0;
    end else begin
      poll_o <= 1'b0;
      if (refresh_tick_i && poll_cnt_i != '0) begin
        if (cnt_q >= last_c) begin
          cnt_q  <= '0;
          poll_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R1
  poll_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |-> ($past(refresh_tick_i) && $past(poll_cnt_i) != '0));
endmodule

// File: rtl/tds_mr_reader.sv
module tds_mr_reader
  import temp_derate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poll_i,
  input  logic cs1_used_i,
  input  logic ack_i,
  input  lvl_t data_i,
  output logic req_o,
  output logic cs_o,
  output logic done_o,
  output lvl_t raw_o
);
  rd_state_e state_q;
  lvl_t      cap_q;

  assign req_o = state_q != RD_IDLE;
  assign cs_o  = state_q == RD_CS1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      cap_q   <= '0;
      raw_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (poll_i) state_q <= RD_CS0;  // polls while busy are dropped
        RD_CS0: if (ack_i) begin
          if (cs1_used_i) begin
            cap_q   <= data_i;
            state_q <= RD_CS1;
          end else begin
            raw_o   <= data_i;
            done_o  <= 1'b1;
            state_q <= RD_IDLE;
          end
        end
        RD_CS1: if (ack_i) begin
          raw_o   <= (data_i > cap_q) ? data_i : cap_q;
          done_o  <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  // R2
  cs_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> ($past(ack_i) && $past(req_o)));
endmodule

// File: rtl/tds_level_tracker.sv
module tds_level_tracker
  import temp_derate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  lvl_t raw_i,
  input  logic ext_temp_i,
  input  logic fall_apply_i,
  output lvl_t lvl_o,
  output logic alert_o
);
  lvl_t tgt_q;
  lvl_t lvl_q;
  lvl_t new_c;
  logic ok_c;

  assign new_c = lvl_map(raw_i, ext_temp_i);
  assign ok_c  = lvl_ok(raw_i);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= LVL_NOM;
      lvl_q   <= LVL_NOM;
      alert_o <= 1'b0;
    end else begin
      alert_o <= 1'b0;
      if (done_i && ok_c) begin
        alert_o <= new_c != tgt_q;
        tgt_q   <= new_c;
        if (new_c > lvl_q) lvl_q <= new_c;     // rise: immediate
      end else if (fall_apply_i && tgt_q < lvl_q) begin
        lvl_q <= tgt_q;                          // fall: deferred
      end
    end
  end

  // R3
  lvl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q >= LVL_NOM && lvl_q != LVL_RSVD);
  // R5
  no_early_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q < $past(lvl_q)) |-> $past(fall_apply_i));
  // R10
  alert_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> !alert_o);
endmodule

// File: rtl/tds_set_selector.sv
module tds_set_selector
  import temp_derate_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lvl_t          lvl_i,
  input  logic          cmd_idle_i,
  input  logic [TW-1:0] nom_tim1_i,
  input  logic [TW-1:0] nom_tim3_i,
  input  logic [TW-1:0] nom_ref_i,
  input  logic [TW-1:0] der_tim1_i,
  input  logic [TW-1:0] der_tim3_i,
  input  logic [TW-1:0] der_ref_i,
  output logic [TW-1:0] tim1_o,
  output logic [TW-1:0] tim3_o,
  output logic [TW-1:0] ref_o
);
  logic der_ref_c, der_ac_c;

  assign der_ac_c  = lvl_i >= LVL_DALL;
  assign der_ref_c = der_ac_c || lvl_i == LVL_DREF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim1_o <= '0;
      tim3_o <= '0;
      ref_o  <= '0;
    end else if (cmd_idle_i) begin
      tim1_o <= der_ac_c  ? der_tim1_i : nom_tim1_i;
      tim3_o <= der_ac_c  ? der_tim3_i : nom_tim3_i;
      ref_o  <= der_ref_c ? der_ref_i  : nom_ref_i;
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmd_idle_i) |-> ($stable(tim1_o) && $stable(tim3_o) && $stable(ref_o)));
endmodule

// File: rtl/temp_derate_sel.sv
module temp_derate_sel
  import temp_derate_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refresh_tick_i,
  input  logic [CNT_W-1:0] poll_cnt_i,
  input  logic             cs1_used_i,
  input  logic             ext_temp_i,
  output logic             mr_req_o,
  output logic             mr_cs_o,
  input  logic             mr_ack_i,
  input  logic [2:0]       mr_data_i,
  input  logic             fall_apply_i,
  input  logic             cmd_idle_i,
  input  logic [TW-1:0]    nom_tim1_i,
  input  logic [TW-1:0]    nom_tim3_i,
  input  logic [TW-1:0]    nom_ref_i,
  input  logic [TW-1:0]    der_tim1_i,
  input  logic [TW-1:0]    der_tim3_i,
  input  logic [TW-1:0]    der_ref_i,
  output logic [TW-1:0]    tim1_o,
  output logic [TW-1:0]    tim3_o,
  output logic [TW-1:0]    ref_o,
  output logic [2:0]       level_o,
  output logic             alert_o,
  output logic             shutdown_o
);
  logic poll_w, done_w;
  lvl_t raw_w, lvl_w;

  tds_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .refresh_tick_i, .poll_cnt_i, .poll_o(poll_w)
  );

  tds_mr_reader u_reader (
    .clk_i, .rst_ni, .poll_i(poll_w), .cs1_used_i, .ack_i(mr_ack_i),
    .data_i(mr_data_i), .req_o(mr_req_o), .cs_o(mr_cs_o),
    .done_o(done_w), .raw_o(raw_w)
  );

  tds_level_tracker u_level (
    .clk_i, .rst_ni, .done_i(done_w), .raw_i(raw_w), .ext_temp_i,
    .fall_apply_i, .lvl_o(lvl_w), .alert_o
  );

  tds_set_selector #(.TW(TW)) u_sel (
    .clk_i, .rst_ni, .lvl_i(lvl_w), .cmd_idle_i,
    .nom_tim1_i, .nom_tim3_i, .nom_ref_i,
    .der_tim1_i, .der_tim3_i, .der_ref_i,
    .tim1_o, .tim3_o, .ref_o
  );

  assign level_o    = lvl_w;
  assign shutdown_o = lvl_w == LVL_SHUT;

  // R8
  shut_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> $past(done_w));
endmodule

// File: tb/temp_derate_sel_tb_top.sv
module temp_derate_sel_tb_top;
  localparam int CNT_W = 16;
  localparam int TW = 32;
  localparam logic [TW-1:0] NT1 = 32'h1111_0001, NT3 = 32'h1111_0003, NRF = 32'h1111_000F;
  localparam logic [TW-1:0] DT1 = 32'hDDDD_0001, DT3 = 32'hDDDD_0003, DRF = 32'hDDDD_000F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, cs1 = 1'b0, ext = 1'b1, ack = 1'b0, fall_ap = 1'b0, idle = 1'b1;
  logic [CNT_W-1:0] pcnt = '0;
  logic [2:0] mdata = '0;
  logic req, mcs, alert, shut;
  logic [2:0] lvl;
  logic [TW-1:0] t1, t3, rf;

  int checks = 0, fails = 0, ack_cnt = 0, resp_dly = 2;
  int d0 = 3, d1 = 3;
  int exp_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  temp_derate_sel #(.CNT_W(CNT_W), .TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .refresh_tick_i(tick), .poll_cnt_i(pcnt),
    .cs1_used_i(cs1), .ext_temp_i(ext), .mr_req_o(req), .mr_cs_o(mcs),
    .mr_ack_i(ack), .mr_data_i(mdata), .fall_apply_i(fall_ap), .cmd_idle_i(idle),
    .nom_tim1_i(NT1), .nom_tim3_i(NT3), .nom_ref_i(NRF),
    .der_tim1_i(DT1), .der_tim3_i(DT3), .der_ref_i(DRF),
    .tim1_o(t1), .tim3_o(t3), .ref_o(rf), .level_o(lvl), .alert_o(alert),
    .shutdown_o(shut)
  );

  task automatic chk(bit ok, string req_s, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  // responder: mode-register read target
  initial forever begin
    @(negedge clk);
    if (req && !ack) begin
      repeat (resp_dly) @(negedge clk);
      mdata = mcs ? 3'(d1) : 3'(d0);
      ack = 1'b1;
      ack_cnt++;
      @(negedge clk);
      ack = 1'b0;
    end
  end

  // monitor: pops expected level at each alert
  initial forever begin
    @(negedge clk);
    if (rst_n && alert) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected alert", lvl, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(lvl == 3'(e), "R10/R5 level at alert", lvl, e);
      end
    end
  end

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // driver: push expectation, trigger one poll, let it settle
  task automatic poll(int a, int b, bit exp_alert, int exp_lvl);
    d0 = a; d1 = b;
    if (exp_alert) exp_q.push_back(exp_lvl);
    pulse_tick();
    repeat (25) @(negedge clk);
  endtask

  task automatic chk_set(bit dt, bit dr, string tag);
    chk(t1 == (dt ? DT1 : NT1), tag, t1, dt ? DT1 : NT1);
    chk(t3 == (dt ? DT3 : NT3), tag, t3, dt ? DT3 : NT3);
    chk(rf == (dr ? DRF : NRF), tag, rf, dr ? DRF : NRF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    chk(lvl == 3'd3, "R3 reset level", lvl, 3);
    chk(!req && !alert && !shut, "R10 reset outputs", {req, alert, shut}, 0);
    chk(t1 == '0, "R7 reset word", t1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_set(0, 0, "R6 nominal after reset");

    // R1: period of 4 ticks
    pcnt = 4;
    a0 = ack_cnt;
    repeat (3) pulse_tick();
    repeat (10) @(negedge clk);
    chk(ack_cnt == a0, "R1 no read before period", ack_cnt - a0, 0);
    pulse_tick();
    repeat (10) @(negedge clk);
    chk(ack_cnt == a0 + 1, "R1 read at period", ack_cnt - a0, 1);
    // R1: zero disables
    pcnt = 0;
    a0 = ack_cnt;
    repeat (3) pulse_tick();
    repeat (10) @(negedge clk);
    chk(ack_cnt == a0, "R1 zero period", ack_cnt - a0, 0);

    // R9: polls during slow read dropped
    pcnt = 1;
    resp_dly = 14;
    a0 = ack_cnt;
    repeat (4) pulse_tick();
    repeat (30) @(negedge clk);
    chk(ack_cnt == a0 + 1, "R9 skipped polls", ack_cnt - a0, 1);
    resp_dly = 2;

    // R6: refresh-only derate
    poll(5, 0, 1, 5);
    chk(lvl == 3'd5, "R6 level 5", lvl, 5);
    chk_set(0, 1, "R6 refresh-only derate");

    // R2: max of two chip selects
    cs1 = 1'b1;
    poll(3, 6, 1, 6);
    chk(lvl == 3'd6, "R2 max of chip selects", lvl, 6);
    chk_set(1, 1, "R6 full derate");

    // R4: reserved code ignored
    poll(4, 4, 0, 0);
    chk(lvl == 3'd6, "R4 reserved ignored", lvl, 6);
    poll(2, 4, 0, 0);
    chk(lvl == 3'd6, "R4 reserved after max", lvl, 6);

    // R3/R5: sub-nominal fall is deferred
    poll(1, 0, 1, 6);
    chk(lvl == 3'd6, "R5 fall held pending", lvl, 6);
    chk_set(1, 1, "R5 words held pending");
    @(negedge clk) fall_ap = 1'b1;
    @(negedge clk) fall_ap = 1'b0;
    chk(lvl == 3'd3, "R3 fall applied to nominal", lvl, 3);
    repeat (2) @(negedge clk);
    chk_set(0, 0, "R6 back to nominal");

    // R7: no switch while busy
    idle = 1'b0;
    poll(5, 0, 1, 5);
    chk(rf == NRF, "R7 held while busy", rf, NRF);
    idle = 1'b1;
    repeat (2) @(negedge clk);
    chk_set(0, 1, "R7 switched when idle");

    // R8: non-extended part converts to shutdown
    ext = 1'b0;
    poll(5, 3, 1, 7);
    chk(lvl == 3'd7, "R8 shutdown level", lvl, 7);
    chk(shut == 1'b1, "R8 shutdown flag", shut, 1);
    chk_set(1, 1, "R6 shutdown derate");

    chk(exp_q.size() == 0, "R10 all alerts seen", exp_q.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule